// File: doc/BRIEF.md
# Chop-Locked Count-and-Dump Decimator

This block turns a single-bit oversampled stream into a multi-bit result by counting the ones in fixed windows. It is a first-order sinc filter. Each window spans a whole number of periods of a slow chopping signal, and every window starts on a rising edge of that signal. Any ripple at the chopping rate therefore falls into a notch of the filter and leaves no trace in the result.

The upstream modulator delivers one bit per clock together with a strobe that marks the bit as a real sample. The chop-state input toggles far more slowly. After reset the block waits for the first rising edge of the chop input. It then counts valid ones continuously. At every `N_PER`-th rising edge it publishes the count and raises a one-cycle pulse, and it starts the next window in the same cycle. No gap appears between windows and no sample is dropped.

Top module: `chop_sinc1_dec`

## Requirements
- R1: A window closes on the rising edge of `chop_in` that comes exactly `N_PER` rising edges after the edge that opened it. No result appears at the intermediate edges.
- R2: After reset, nothing is counted or reported until the first rising edge of `chop_in`. A `chop_in` level that is already high when reset is released is not an edge.
- R3: A result equals the number of cycles that have `smp_vld` = 1 and `smp_bit` = 1. The counted span runs from the window's opening edge cycle through the cycle before its closing edge. The sample in the closing edge cycle belongs to the next window, which opens in that same cycle.
- R4: `res_vld` is high for exactly one cycle, in the cycle after the closing edge. `res_cnt` carries the result in that same cycle.
- R5: `res_cnt` and `res_vld` are zero after reset, and `res_cnt` changes only when `res_vld` is high.
- R6: A cycle with `smp_vld` = 0 has no effect on any count, whatever the value of `smp_bit`.
- R7: `res_cnt` is `CW` bits wide. The number of samples in one window must not exceed 2^`CW` - 1, so the count never wraps.
- R8: A bit density that depends on the chop phase gives the same exact count in every window, because each window holds the same whole number of chop periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_bit | input | 1 | Modulator output bit |
| smp_vld | input | 1 | High when `smp_bit` is a real sample |
| chop_in | input | 1 | Slow chop-state signal |
| res_cnt | output | CW | Count of ones in the last finished window |
| res_vld | output | 1 | One-cycle pulse marking a new `res_cnt` |

## Verification
The bench builds the block with `CW` = 8 and `N_PER` = 2, and drives a chop period of 16 clocks, so each window is 32 clocks long. This short window lets several back-to-back windows with different bit patterns run in a few hundred cycles. It also places the intermediate chop edge, where no result may appear, early enough to observe. With windows this short, chop-correlated densities and strobe gating can be checked against exact, hand-computed counts.

// File: rtl/chop_dec_pkg.sv
package chop_dec_pkg;
  typedef enum logic {
    SEQ_WAIT = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/chop_edge_det.sv
module chop_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic chop_i,
  output logic rise_o
);
  logic chop_q;
  logic chop_d;

  // Reset value 1: a chop already high at reset release is not an edge (R2).
  always_comb chop_d = chop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chop_q <= 1'b1;
    else        chop_q <= chop_d;
  end

  assign rise_o = chop_i & ~chop_q;
endmodule

// File: rtl/win_seq.sv
module win_seq
  import chop_dec_pkg::*;
#(
  parameter int N_PER = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic run_o,
  output logic start_o,
  output logic wend_o
);
  localparam int PW = (N_PER > 1) ? $clog2(N_PER) : 1;
  localparam logic [PW-1:0] LAST = PW'(N_PER - 1);

  seq_state_e st_q, st_d;
  logic [PW-1:0] per_q, per_d;

  always_comb begin
    st_d    = st_q;
    per_d   = per_q;
    start_o = 1'b0;
    wend_o  = 1'b0;
    if (rise_i) begin
      if (st_q == SEQ_WAIT) begin
        st_d    = SEQ_RUN;
        per_d   = '0;
        start_o = 1'b1;
      end else if (per_q == LAST) begin
        per_d  = '0;
        wend_o = 1'b1;
      end else begin
        per_d = per_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_WAIT;
      per_q <= '0;
    end else begin
      st_q  <= st_d;
      per_q <= per_d;
    end
  end

  assign run_o = (st_q == SEQ_RUN);

  // R1: a window end only ever falls on a chop rising edge
  p_end_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wend_o |-> rise_i);

  // R2: no window end while still waiting for the first edge
  p_no_end_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> !wend_o);
endmodule

// File: rtl/ones_acc.sv
module ones_acc #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          start_i,
  input  logic          wend_i,
  input  logic          bit_i,
  input  logic          vld_i,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_vld_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] acc_q, acc_d;
  logic [CW-1:0] out_q, out_d;
  logic          pv_q, pv_d;
  logic          take;

  always_comb begin
    take  = vld_i & bit_i;
    acc_d = acc_q;
    out_d = out_q;
    pv_d  = 1'b0;
    if (start_i || wend_i) begin
      acc_d = CW'(take);
    end else if (run_i && take) begin
      acc_d = acc_q + 1'b1;
    end
    if (wend_i) begin
      out_d = acc_q;
      pv_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= '0;
      pv_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      out_q <= out_d;
      pv_q  <= pv_d;
    end
  end

  assign cnt_o     = out_q;
  assign cnt_vld_o = pv_q;

  // R7: the window must never hold more ones than CW bits can count
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_i && !wend_i && take && acc_q == CMAX));

  // R4: result pulse lasts one cycle
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_vld_o |=> !cnt_vld_o);

  // R4: pulse follows a window end by one cycle
  p_pulse_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wend_i |=> cnt_vld_o);

  // R5: result word moves only together with its pulse
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_o) |-> cnt_vld_o);
endmodule

// File: rtl/chop_sinc1_dec.sv
module chop_sinc1_dec #(
  parameter int CW    = 14,
  parameter int N_PER = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_bit,
  input  logic          smp_vld,
  input  logic          chop_in,
  output logic [CW-1:0] res_cnt,
  output logic          res_vld
);
  logic rise, run, start, wend;

  chop_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .chop_i (chop_in),
    .rise_o (rise)
  );

  win_seq #(.N_PER(N_PER)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (rise),
    .run_o   (run),
    .start_o (start),
    .wend_o  (wend)
  );

  ones_acc #(.CW(CW)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .start_i   (start),
    .wend_i    (wend),
    .bit_i     (smp_bit),
    .vld_i     (smp_vld),
    .cnt_o     (res_cnt),
    .cnt_vld_o (res_vld)
  );

  // R2: no result can appear before counting has begun
  p_quiet_before_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> !res_vld);
endmodule

// File: tb/tb_chop_sinc1_dec.sv
module tb_chop_sinc1_dec;
  localparam int CW   = 8;
  localparam int NPER = 2;
  localparam int HALF = 8;
  localparam int WLEN = 4 * HALF;
  localparam int NENT = 7;

  // {mode[3:0], expected[7:0]}
  localparam logic [11:0] TBL [NENT] = '{
    {4'd0, 8'd32},   // all ones (R3)
    {4'd1, 8'd0},    // all zeros (R3)
    {4'd2, 8'd8},    // one in four (R3)
    {4'd3, 8'd24},   // chop-correlated density (R8)
    {4'd3, 8'd24},   // repeated window, same count (R8)
    {4'd4, 8'd16},   // ones, strobe every other cycle (R6)
    {4'd5, 8'd11}    // one in three (R3)
  };

  logic clk = 1'b0;
  logic rst_n;
  logic smp_bit, smp_vld, chop_in;
  logic [CW-1:0] res_cnt;
  logic res_vld;

  int n_chk = 0;
  int n_bad = 0;
  int nres = 0;
  logic [CW-1:0] got [16];
  logic prev_vld = 1'b0;
  logic mon_on = 1'b0;

  always #2.5 clk = ~clk;

  chop_sinc1_dec #(.CW(CW), .N_PER(NPER)) dut (
    .clk(clk), .rst_n(rst_n), .smp_bit(smp_bit), .smp_vld(smp_vld),
    .chop_in(chop_in), .res_cnt(res_cnt), .res_vld(res_vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic drive(input logic b, input logic v, input logic c);
    smp_bit = b;
    smp_vld = v;
    chop_in = c;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] pat(input logic [3:0] m, input int k);
    logic chp;
    chp = ((k % (2 * HALF)) < HALF);
    case (m)
      4'd0: return 2'b11;
      4'd1: return 2'b01;
      4'd2: return {(k % 4) == 0, 1'b1};
      4'd3: return {chp ? 1'b1 : logic'(k % 2), 1'b1};
      4'd4: return {1'b1, logic'((k % 2) == 0)};
      default: return {(k % 3) == 0, 1'b1};
    endcase
  endfunction

  // output monitor, samples away from the active edge
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (res_vld && prev_vld)
        check(1'b0, "R4 pulse width", 2, 1);
      if (res_vld && nres < 16) begin
        got[nres] = res_cnt;
        nres++;
      end
      prev_vld = res_vld;
    end
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] bv;
    rst_n = 1'b0;
    smp_bit = 1'b1; smp_vld = 1'b1; chop_in = 1'b1;
    repeat (3) drive(1'b1, 1'b1, 1'b1);
    rst_n = 1'b1;
    #1;
    // R5: reset state
    check(res_cnt == '0, "R5 reset count", int'(res_cnt), 0);
    check(res_vld == 1'b0, "R5 reset valid", int'(res_vld), 0);
    mon_on = 1'b1;
    // R2: chop high through reset release is no edge
    repeat (6) drive(1'b1, 1'b1, 1'b1);
    repeat (4) drive(1'b1, 1'b1, 1'b0);
    #1;
    check(nres == 0, "R2 no result before first edge", nres, 0);

    for (int e = 0; e < NENT; e++) begin
      for (int k = 0; k < WLEN; k++) begin
        bv = pat(TBL[e][11:8], k);
        drive(bv[1], bv[0], ((k % (2 * HALF)) < HALF));
        if (e == 0 && k == HALF * 2 + 3)
          check(nres == 0, "R1 no result at intermediate edge", nres, 0);
      end
    end
    drive(1'b0, 1'b1, 1'b1);
    repeat (3) drive(1'b0, 1'b1, 1'b1);

    check(nres == NENT, "R1 number of windows", nres, NENT);
    for (int e = 0; e < NENT; e++) begin
      case (TBL[e][11:8])
        4'd3: check(got[e] == TBL[e][7:0], "R8 chop-correlated count",
                    int'(got[e]), int'(TBL[e][7:0]));
        4'd4: check(got[e] == TBL[e][7:0], "R6 strobe-gated count",
                    int'(got[e]), int'(TBL[e][7:0]));
        default: check(got[e] == TBL[e][7:0], "R3 window count",
                       int'(got[e]), int'(TBL[e][7:0]));
      endcase
    end
    // R5/R7: last result held, all within CW bits
    #1;
    check(res_cnt == TBL[NENT-1][7:0], "R5 result held", int'(res_cnt),
          int'(TBL[NENT-1][7:0]));
    check(res_vld == 1'b0, "R4 pulse dropped", int'(res_vld), 0);

    // mid-window reset returns to the reset state
    repeat (5) drive(1'b1, 1'b1, 1'b1);
    rst_n = 1'b0;
    #1;
    check(res_cnt == '0 && res_vld == 1'b0, "R5 reset mid-window", int'(res_cnt), 0);
    drive(1'b1, 1'b1, 1'b0);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule